// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache of `N_ENTRIES` slots. Each slot describes a pair of adjacent virtual pages that share one tag. The pair maps onto two independent physical frames, one for the even page and one for the odd page. Every slot carries a page-size mask, so the page size can be 4 KB or any larger power-of-two size that the mask describes. Each slot also holds an 8-bit address-space identifier, a global flag, and a valid bit and a dirty bit for each half.

Software or a refill engine loads a whole slot in one clock through a synchronous write port, addressed by slot index. Lookups are purely combinational. A lookup takes a virtual address, the current address-space identifier and a store/load flag. It returns a physical address, a write-permission flag and a two-bit outcome code. The block does not choose which slot to replace and does not handle refills.

Top module: `pair_tlb`

## Requirements
- R1: A slot hits when the lookup address, with the slot's effective mask bits cleared, equals the slot's tag with the same bits cleared. The slot's global flag must also be set, or its identifier must equal `lk_asid`. A slot whose identifier differs and whose global flag is clear does not hit.
- R2: The effective mask is `wr_pmask | 0x1FFF`. A pair therefore always spans at least 8 KB. A wider mask widens the pair, and every address inside the pair hits the slot.
- R3: The half is selected by the highest set bit of the effective mask, which is bit 12 for 4 KB pages. When that address bit is 0 the even frame is used, and when it is 1 the odd frame is used.
- R4: If the selected half has its valid bit clear, `lk_result` is 2 (invalid). This holds for loads and for stores.
- R5: A store (`lk_write`=1) to a valid half whose dirty bit is clear gives `lk_result` 3 (modify fault). A load from that half gives `lk_result` 0 with `lk_writable`=0.
- R6: On a successful lookup (`lk_result`=0), `lk_paddr` is the selected frame value ORed with the address bits under the effective mask shifted right by one. `lk_writable` equals the selected dirty bit.
- R7: When no slot hits, `lk_result` is 1 (no match). For every result other than 0, `lk_paddr` and `lk_writable` are 0.
- R8: When several slots hit, the slot with the lowest index decides the outcome, even if that slot's half is invalid.
- R9: A write with `wr_en`=1 updates the slot at `wr_idx` at the rising edge. Lookups see the new contents from the following cycle onward. In `wr_valid` and `wr_dirty`, bit 0 belongs to the even half and bit 1 to the odd half.
- R10: An active-low reset clears every field of every slot. Until the first write, no lookup returns 0. For example, address 0x1000 with identifier 0 gives 2, and address 0x80000000 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load a slot this cycle |
| wr_idx | input | IDX_W | Slot to load |
| wr_vpn | input | ADDR_W | Virtual tag of the pair |
| wr_asid | input | ASID_W | Address-space identifier of the slot |
| wr_pmask | input | ADDR_W | Page-size mask (bits above the 8 KB pair) |
| wr_global | input | 1 | Slot matches any identifier |
| wr_pfn_even | input | ADDR_W | Physical frame of the even page |
| wr_pfn_odd | input | ADDR_W | Physical frame of the odd page |
| wr_valid | input | 2 | Valid bits, [0] even, [1] odd |
| wr_dirty | input | 2 | Dirty (writable) bits, [0] even, [1] odd |
| lk_vaddr | input | ADDR_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is for a store |
| lk_paddr | output | ADDR_W | Translated physical address |
| lk_writable | output | 1 | Store permitted to this page |
| lk_result | output | 2 | 0 hit, 1 no match, 2 invalid, 3 modify fault |

## Verification
The assertions assume that a loaded page mask is a contiguous run of ones starting at bit 13. They also assume that frame values have zero bits under the page offset. Under those conditions a single slot hit maps onto exactly one half. The stimulus meets these assumptions in two ways. Directed loads use fixed, aligned frames. Random loads take their masks from a small set of contiguous masks and their frames from values aligned to the largest such page. Random tags and lookup addresses come from a few shared regions, so that overlapping slots and first-hit ordering occur often.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  typedef enum logic [1:0] {
    RES_HIT     = 2'd0,
    RES_MISS    = 2'd1,
    RES_INVALID = 2'd2,
    RES_MODIFY  = 2'd3
  } tlb_res_e;
endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store #(
  parameter int N      = 16,
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [ADDR_W-1:0]            wr_vpn,
  input  logic [ASID_W-1:0]            wr_asid,
  input  logic [ADDR_W-1:0]            wr_pmask,
  input  logic                         wr_global,
  input  logic [ADDR_W-1:0]            wr_pfn_even,
  input  logic [ADDR_W-1:0]            wr_pfn_odd,
  input  logic [1:0]                   wr_valid,
  input  logic [1:0]                   wr_dirty,
  output logic [N-1:0][ADDR_W-1:0]     st_vpn,
  output logic [N-1:0][ASID_W-1:0]     st_asid,
  output logic [N-1:0][ADDR_W-1:0]     st_pmask,
  output logic [N-1:0]                 st_glb,
  output logic [N-1:0][ADDR_W-1:0]     st_pfn0,
  output logic [N-1:0][ADDR_W-1:0]     st_pfn1,
  output logic [N-1:0][1:0]            st_valid,
  output logic [N-1:0][1:0]            st_dirty
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_vpn[g]   <= '0;
        st_asid[g]  <= '0;
        st_pmask[g] <= '0;
        st_glb[g]   <= 1'b0;
        st_pfn0[g]  <= '0;
        st_pfn1[g]  <= '0;
        st_valid[g] <= 2'b00;
        st_dirty[g] <= 2'b00;
      end else if (sel_w) begin
        st_vpn[g]   <= wr_vpn;
        st_asid[g]  <= wr_asid;
        st_pmask[g] <= wr_pmask;
        st_glb[g]   <= wr_global;
        st_pfn0[g]  <= wr_pfn_even;
        st_pfn1[g]  <= wr_pfn_odd;
        st_valid[g] <= wr_valid;
        st_dirty[g] <= wr_dirty;
      end
    end
  end
endmodule

// File: rtl/pair_tlb_probe.sv
module pair_tlb_probe #(
  parameter int ADDR_W    = 32,
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [ADDR_W-1:0] e_pmask,
  input  logic              e_glb,
  input  logic [ADDR_W-1:0] e_pfn0,
  input  logic [ADDR_W-1:0] e_pfn1,
  input  logic [1:0]        e_valid,
  input  logic [1:0]        e_dirty,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic              sel_valid,
  output logic              sel_dirty,
  output logic [ADDR_W-1:0] pa
);
  localparam logic [ADDR_W-1:0] MIN_MASK =
    {{(ADDR_W-PAGE_BITS-1){1'b0}}, {(PAGE_BITS+1){1'b1}}};

  function automatic logic [ADDR_W-1:0] eff_mask(input logic [ADDR_W-1:0] pm);
    return pm | MIN_MASK;
  endfunction

  function automatic logic half_sel(input logic [ADDR_W-1:0] va,
                                    input logic [ADDR_W-1:0] m);
    return |(va & m & ~(m >> 1));
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [ADDR_W-1:0] pfn,
                                                   input logic [ADDR_W-1:0] va,
                                                   input logic [ADDR_W-1:0] m);
    return pfn | (va & (m >> 1));
  endfunction

  logic [ADDR_W-1:0] mask_w;
  logic              tag_eq;
  logic              asid_ok;
  logic              odd_w;

  assign mask_w    = eff_mask(e_pmask);
  assign tag_eq    = ((lk_vaddr & ~mask_w) == (e_vpn & ~mask_w));
  assign asid_ok   = e_glb || (e_asid == lk_asid);
  assign hit       = tag_eq && asid_ok;
  assign odd_w     = half_sel(lk_vaddr, mask_w);
  assign sel_valid = odd_w ? e_valid[1] : e_valid[0];
  assign sel_dirty = odd_w ? e_dirty[1] : e_dirty[0];
  assign pa        = frame_addr(odd_w ? e_pfn1 : e_pfn0, lk_vaddr, mask_w);
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick
  import pair_tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             hit_vec,
  input  logic [N-1:0]             valid_vec,
  input  logic [N-1:0]             dirty_vec,
  input  logic [N-1:0][ADDR_W-1:0] pa_vec,
  input  logic                     lk_write,
  output logic [N-1:0]             first_hit,
  output tlb_res_e                 result,
  output logic [ADDR_W-1:0]        paddr,
  output logic                     writable
);
  logic [IDX_W-1:0] win_idx;
  logic             any_hit;

  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    first_hit = '0;
    if (any_hit) first_hit[win_idx] = 1'b1;
  end

  always_comb begin
    result   = RES_MISS;
    paddr    = '0;
    writable = 1'b0;
    if (any_hit) begin
      if (!valid_vec[win_idx]) begin
        result = RES_INVALID;
      end else if (lk_write && !dirty_vec[win_idx]) begin
        result = RES_MODIFY;
      end else begin
        result   = RES_HIT;
        paddr    = pa_vec[win_idx];
        writable = dirty_vec[win_idx];
      end
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [ADDR_W-1:0] wr_pmask,
  input  logic              wr_global,
  input  logic [ADDR_W-1:0] wr_pfn_even,
  input  logic [ADDR_W-1:0] wr_pfn_odd,
  input  logic [1:0]        wr_valid,
  input  logic [1:0]        wr_dirty,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic [ADDR_W-1:0] lk_paddr,
  output logic              lk_writable,
  output logic [1:0]        lk_result
);
  logic [N_ENTRIES-1:0][ADDR_W-1:0] st_vpn, st_pmask, st_pfn0, st_pfn1, pa_vec;
  logic [N_ENTRIES-1:0][ASID_W-1:0] st_asid;
  logic [N_ENTRIES-1:0]             st_glb;
  logic [N_ENTRIES-1:0][1:0]        st_valid, st_dirty;
  logic [N_ENTRIES-1:0]             hit_vec, valid_vec, dirty_vec, first_hit;
  tlb_res_e                         res_w;

  pair_tlb_store #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .ASID_W(ASID_W)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pmask(wr_pmask),
    .wr_global(wr_global), .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .st_vpn(st_vpn), .st_asid(st_asid), .st_pmask(st_pmask), .st_glb(st_glb),
    .st_pfn0(st_pfn0), .st_pfn1(st_pfn1), .st_valid(st_valid), .st_dirty(st_dirty)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_probe
    pair_tlb_probe #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .PAGE_BITS(PAGE_BITS)) probe_i (
      .e_vpn(st_vpn[g]), .e_asid(st_asid[g]), .e_pmask(st_pmask[g]),
      .e_glb(st_glb[g]), .e_pfn0(st_pfn0[g]), .e_pfn1(st_pfn1[g]),
      .e_valid(st_valid[g]), .e_dirty(st_dirty[g]),
      .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
      .hit(hit_vec[g]), .sel_valid(valid_vec[g]), .sel_dirty(dirty_vec[g]),
      .pa(pa_vec[g])
    );
  end

  pair_tlb_pick #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) pick_i (
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .pa_vec(pa_vec), .lk_write(lk_write), .first_hit(first_hit),
    .result(res_w), .paddr(lk_paddr), .writable(lk_writable)
  );

  assign lk_result = res_w;
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int N      = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              lk_write,
  input logic [1:0]        lk_result,
  input logic              lk_writable,
  input logic [ADDR_W-1:0] lk_paddr,
  input logic [N-1:0]      hit_vec,
  input logic [N-1:0]      first_hit
);
  logic written;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     written <= 1'b0;
    else if (wr_en) written <= 1'b1;
  end

  // R7
  fault_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_result != 2'd0) |-> (lk_paddr == '0 && !lk_writable));

  // R7
  nohit_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (lk_result == 2'd1));

  // R6
  writable_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_writable |-> (lk_result == 2'd0));

  // R5
  store_hit_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_result == 2'd0 && lk_write) |-> lk_writable);

  // R8
  winner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_hit));

  // R8
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> ((first_hit & hit_vec) == first_hit && first_hit != '0 &&
                         (hit_vec & (first_hit - 1'b1)) == '0));

  // R10
  reset_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !written |-> (lk_result != 2'd0));
endmodule

bind pair_tlb pair_tlb_chk #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lk_write(lk_write),
  .lk_result(lk_result), .lk_writable(lk_writable), .lk_paddr(lk_paddr),
  .hit_vec(hit_vec), .first_hit(first_hit)
);

// File: tb/pair_tlb_tb_top.sv
`timescale 1ns/1ps
module pair_tlb_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [1:0]  wr_valid = '0, wr_dirty = '0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0;
  logic [31:0] lk_paddr;
  logic        lk_writable;
  logic [1:0]  lk_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit running = 0;
  string cur_tag = "R10";

  always #10 clk = ~clk;

  pair_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pmask(wr_pmask),
    .wr_global(wr_global), .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
    .lk_paddr(lk_paddr), .lk_writable(lk_writable), .lk_result(lk_result)
  );

  // behavioural reference table
  logic [31:0] m_vpn[N], m_pm[N], m_f0[N], m_f1[N];
  logic [7:0]  m_asid[N];
  logic        m_g[N];
  logic [1:0]  m_v[N], m_d[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_vpn[k] = 0; m_pm[k] = 0; m_f0[k] = 0; m_f1[k] = 0;
        m_asid[k] = 0; m_g[k] = 0; m_v[k] = 0; m_d[k] = 0;
      end
    end else if (wr_en) begin
      m_vpn[wr_idx] = wr_vpn; m_pm[wr_idx] = wr_pmask; m_f0[wr_idx] = wr_pfn_even;
      m_f1[wr_idx] = wr_pfn_odd; m_asid[wr_idx] = wr_asid; m_g[wr_idx] = wr_global;
      m_v[wr_idx] = wr_valid; m_d[wr_idx] = wr_dirty;
    end
  end

  task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic w,
                       output logic [1:0] res, output logic [31:0] pa, output logic wok);
    longint span, half;
    bit odd, found;
    res = 2'd1; pa = 0; wok = 0; found = 0;
    for (int k = 0; k < N; k++) begin
      if (!found) begin
        span = longint'(m_pm[k] | 32'h1FFF) + 1;
        half = span / 2;
        if ((longint'(va) / span == longint'(m_vpn[k]) / span) &&
            (m_g[k] || m_asid[k] == asid)) begin
          found = 1;
          odd = (longint'(va) % span) >= half;
          if (!m_v[k][odd]) res = 2'd2;
          else if (w && !m_d[k][odd]) res = 2'd3;
          else begin
            res = 2'd0;
            pa = (odd ? m_f1[k] : m_f0[k]) | 32'(longint'(va) % half);
            wok = m_d[k][odd];
          end
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [1:0] er; logic [31:0] ep; logic ew;
      model(lk_vaddr, lk_asid, lk_write, er, ep, ew);
      checks++;
      if (er !== lk_result || ep !== lk_paddr || ew !== lk_writable) begin
        errors++;
        $display("FAIL %s model: got res=%0d pa=%h wr=%0b exp res=%0d pa=%h wr=%0b",
                 cur_tag, lk_result, lk_paddr, lk_writable, er, ep, ew);
      end
    end
  end

  task automatic expect_out(input string tag, input logic [1:0] r, input logic [31:0] p,
                            input logic w);
    checks++;
    if (lk_result !== r || lk_paddr !== p || lk_writable !== w) begin
      errors++;
      $display("FAIL %s: got res=%0d pa=%h wr=%0b exp res=%0d pa=%h wr=%0b",
               tag, lk_result, lk_paddr, lk_writable, r, p, w);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic w);
    @(posedge clk); #1;
    wr_en = 0; lk_vaddr = va; lk_asid = asid; lk_write = w;
    @(negedge clk);
  endtask

  task automatic load(input int idx, input logic [31:0] vpn, input logic [7:0] asid,
                      input logic [31:0] pm, input logic g, input logic [31:0] f0,
                      input logic [31:0] f1, input logic [1:0] v, input logic [1:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_asid = asid; wr_pmask = pm;
    wr_global = g; wr_pfn_even = f0; wr_pfn_odd = f1; wr_valid = v; wr_dirty = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] regions[4];
    logic [31:0] masks[4];
    regions = '{32'h0040_0000, 32'h0080_0000, 32'h0100_0000, 32'h0200_0000};
    masks   = '{32'h0, 32'h6000, 32'h1_E000, 32'h7_E000};

    // R10: reset state
    lk_vaddr = 32'h1000; lk_asid = 0;
    @(negedge clk); expect_out("R10 reset low region", 2'd2, 0, 0);
    lk_vaddr = 32'h8000_0000;
    @(negedge clk); expect_out("R10 reset high region", 2'd1, 0, 0);
    @(posedge clk); #1 rst_n = 1;
    running = 1;

    // R9: write visible only the cycle after
    cur_tag = "R9";
    look(32'h0040_0123, 8'd5, 0);
    expect_out("R10 no hit after reset", 2'd1, 0, 0);
    load(3, 32'h0040_0000, 8'd5, 0, 0, 32'h1000_0000, 32'h2000_0000, 2'b11, 2'b01);
    expect_out("R9 before edge", 2'd1, 0, 0);
    look(32'h0040_0123, 8'd5, 0);
    expect_out("R9 after edge", 2'd0, 32'h1000_0123, 1);

    // R3 / R5 / R6
    cur_tag = "R3";
    look(32'h0040_1456, 8'd5, 0);
    expect_out("R3 odd half load", 2'd0, 32'h2000_0456, 0);
    look(32'h0040_1456, 8'd5, 1);
    expect_out("R5 store to clean half", 2'd3, 0, 0);
    look(32'h0040_0ffc, 8'd5, 1);
    expect_out("R6 store to dirty half", 2'd0, 32'h1000_0ffc, 1);

    // R1 identifier and global rule
    cur_tag = "R1";
    look(32'h0040_0123, 8'd6, 0);
    expect_out("R1 identifier mismatch", 2'd1, 0, 0);
    load(5, 32'h0080_0000, 8'd9, 0, 1, 32'h7000_0000, 32'h7100_0000, 2'b11, 2'b00);
    look(32'h0080_0040, 8'd6, 0);
    expect_out("R1 global slot", 2'd0, 32'h7000_0040, 0);

    // R4 invalid half
    cur_tag = "R4";
    load(6, 32'h00C0_0000, 8'd5, 0, 0, 32'h6000_0000, 32'h6100_0000, 2'b10, 2'b11);
    look(32'h00C0_0010, 8'd5, 1);
    expect_out("R4 even invalid store", 2'd2, 0, 0);
    look(32'h00C0_0010, 8'd5, 0);
    expect_out("R4 even invalid load", 2'd2, 0, 0);
    look(32'h00C0_1010, 8'd5, 1);
    expect_out("R6 odd valid store", 2'd0, 32'h6100_0010, 1);

    // R2 large pages
    cur_tag = "R2";
    load(7, 32'h0100_0000, 8'd5, 32'h1_E000, 0, 32'h3000_0000, 32'h3001_0000, 2'b11, 2'b11);
    look(32'h0100_F123, 8'd5, 0);
    expect_out("R2 large even", 2'd0, 32'h3000_F123, 1);
    look(32'h0101_0010, 8'd5, 0);
    expect_out("R2 large odd", 2'd0, 32'h3001_0010, 1);
    look(32'h0102_0000, 8'd5, 0);
    expect_out("R2 outside pair", 2'd1, 0, 0);

    // R8 lowest index wins
    cur_tag = "R8";
    load(9, 32'h0200_0000, 8'd0, 0, 1, 32'h5000_0000, 32'h5100_0000, 2'b11, 2'b11);
    load(2, 32'h0200_0000, 8'd0, 0, 1, 32'h4000_0000, 32'h4100_0000, 2'b11, 2'b11);
    look(32'h0200_0abc, 8'd3, 0);
    expect_out("R8 lower slot wins", 2'd0, 32'h4000_0abc, 1);
    load(2, 32'h0200_0000, 8'd0, 0, 1, 32'h4000_0000, 32'h4100_0000, 2'b00, 2'b11);
    look(32'h0200_0abc, 8'd3, 0);
    expect_out("R8 invalid lower slot still wins", 2'd2, 0, 0);

    // R7 no match
    cur_tag = "R7";
    look(32'hF000_0000, 8'd5, 1);
    expect_out("R7 no match", 2'd1, 0, 0);

    // random mix against the reference model
    cur_tag = "R6 random";
    for (int n = 0; n < 2000; n++) begin
      if ($urandom % 4 == 0) begin
        int mi;
        logic [31:0] fb;
        mi = $urandom % 4;
        fb = ($urandom % 64) << 19;
        load($urandom % N, regions[$urandom % 4] + (($urandom % 4) << 17), 8'($urandom % 3),
             masks[mi], ($urandom % 4) == 0, fb, fb | 32'h4_0000,
             2'($urandom), 2'($urandom));
      end else begin
        look(regions[$urandom % 4] + ($urandom % 32'h8_0000), 8'($urandom % 3),
             1'($urandom));
      end
    end
    running = 0;
    finish_run();
  end
endmodule